// File: doc/BRIEF.md
# LPC Host SYNC Phase Monitor

This block lives on the host side of an LPC bus controller and takes over once the turnaround that follows a memory, I/O, DMA or firmware-hub request has finished. From the clock after `start_i` it samples the four LAD lines on every rising edge and reads each nibble as a SYNC code. It counts wait states and closes the transfer with one of four results: ready, ready-more, error or abort. An error SYNC on a memory, I/O or DMA transfer produces a one-clock system-error pulse. A peripheral that stays silent, drives a reserved nibble or drives a code the cycle type does not allow makes the block abort the transfer on the bus.

The controller is a three-state machine. **IDLE** waits for `start_i` and latches the cycle type (transition *launch*, IDLE→SYNC). **SYNC** reads one code per clock. It returns to IDLE on *complete* (ready, ready-more or error) and moves to ABORT on *bail* (silence timeout, reserved or illegal code, firmware-hub error, wait limit). In every other case it stays in SYNC (*hold*). **ABORT** holds the frame line low and drives all-ones on LAD for a fixed number of clocks, then returns to IDLE (*release*) and reports the abort. A float-high nibble (4'b1111) counts as no response. Any other reserved nibble counts as an invalid SYNC.

Top module: `lpc_sync_monitor`

## Requirements
- R1: While reset is held, and on the first clock after it, `lframe_n_o` is 1, `lad_oe_o`, `lad_o`, `done_o`, `serr_o`, `fwh_err_o`, `busy_o` and `wait_cnt_o` are 0.
- R2: `start_i` moves the block from idle to the SYNC phase and latches `cyc_type_i` (0 memory, 1 I/O, 2 DMA, 3 firmware hub). `busy_o` stays high until the cycle ends. `start_i` has no effect while busy.
- R3: A sampled code 4'b0000 ends the cycle. On the next clock `done_o` pulses for one clock with `result_o` = 0 (ready), and `busy_o` falls at the same time.
- R4: Codes 4'b0101 and 4'b0110 keep the block in SYNC, add one to `wait_cnt_o` (cleared at each start) and clear the no-response count.
- R5: Code 4'b1001 on a DMA cycle ends the cycle with `result_o` = 1 (ready-more). On any other cycle type it causes an abort.
- R6: Code 4'b1010 on a memory, I/O or DMA cycle ends the cycle with `result_o` = 2 (error), and `serr_o` pulses in the same clock as `done_o`.
- R7: Code 4'b1010 on a firmware-hub cycle pulses `fwh_err_o` in the first clock of an abort and does not pulse `serr_o`.
- R8: Four consecutive samples of 4'b1111 cause an abort on the fourth sample. Fewer than four, followed by a wait code, do not.
- R9: Any code other than 0000, 0101, 0110, 1001, 1010 and 1111 causes an abort on the clock it is sampled.
- R10: An abort holds `lframe_n_o` low with `lad_oe_o` = 1 and `lad_o` = 4'b1111 for exactly four clocks. On the clock after that, `done_o` pulses with `result_o` = 3 and the block is idle. Outside an abort `lad_oe_o` = 0 and `lad_o` = 0.
- R11: If `MAX_WAIT` is nonzero, a wait code that arrives after `MAX_WAIT` wait codes in the same cycle causes an abort. A zero value removes the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | SYNC phase begins after this clock |
| cyc_type_i | input | 2 | Cycle type: 0 mem, 1 I/O, 2 DMA, 3 firmware hub |
| lad_i | input | 4 | Sampled LAD nibble |
| lad_o | output | 4 | LAD value driven by host during abort |
| lad_oe_o | output | 1 | LAD output enable |
| lframe_n_o | output | 1 | Frame line, active low |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| result_o | output | 2 | 0 ready, 1 ready-more, 2 error, 3 abort |
| serr_o | output | 1 | System-error pulse on error SYNC |
| fwh_err_o | output | 1 | Illegal error SYNC from firmware hub |
| wait_cnt_o | output | WAIT_W | Wait codes seen in current cycle |

## Verification
The bench targets the places where the cycle type decides whether a code is legal. It sends ready-more on I/O and firmware-hub cycles and an error SYNC on a firmware-hub cycle. A decoder that ignored the type would report success there, or raise a system error, where an abort is required. It checks the no-response timeout on both sides of the boundary. Three float-high clocks followed by a wait must not abort, which catches a counter that is never cleared. Four float-high clocks must abort, which catches a counter that is off by one. It also checks the exact four-clock abort window and the wait limit at MAX_WAIT and at MAX_WAIT+1. A stretched window or a misplaced limit shows up as a `done_o` pulse on the wrong clock.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

    typedef enum logic [1:0] {
        CYC_MEM = 2'd0,
        CYC_IO  = 2'd1,
        CYC_DMA = 2'd2,
        CYC_FWH = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        RES_READY = 2'd0,
        RES_MORE  = 2'd1,
        RES_ERROR = 2'd2,
        RES_ABORT = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        CL_READY,
        CL_MORE,
        CL_WAIT,
        CL_ERR,
        CL_FWH_ERR,
        CL_SILENT,
        CL_BAD
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ABORT
    } st_e;

    localparam logic [3:0] CODE_READY = 4'b0000;
    localparam logic [3:0] CODE_SHORT = 4'b0101;
    localparam logic [3:0] CODE_LONG  = 4'b0110;
    localparam logic [3:0] CODE_MORE  = 4'b1001;
    localparam logic [3:0] CODE_ERR   = 4'b1010;
    localparam logic [3:0] CODE_FLOAT = 4'b1111;

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
    import lpc_sync_pkg::*;
(
    input  logic [3:0] code_i,
    input  cyc_e       cyc_i,
    output cls_e       cls_o
);

    // Classify one sampled nibble, folding in cycle-type legality.
    always_comb begin
        unique case (code_i)
            CODE_READY: cls_o = CL_READY;
            CODE_SHORT,
            CODE_LONG:  cls_o = CL_WAIT;
            CODE_MORE:  cls_o = (cyc_i == CYC_DMA) ? CL_MORE : CL_BAD;
            CODE_ERR:   cls_o = (cyc_i == CYC_FWH) ? CL_FWH_ERR : CL_ERR;
            CODE_FLOAT: cls_o = CL_SILENT;
            default:    cls_o = CL_BAD;
        endcase
    end

endmodule

// File: rtl/lpc_sync_wait_track.sv
module lpc_sync_wait_track #(
    parameter int SILENT_CLKS = 4,
    parameter int MAX_WAIT    = 0,
    parameter int CW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          wait_i,
    input  logic          silent_i,
    output logic          timeout_o,
    output logic          limit_o,
    output logic [CW-1:0] waits_o
);

    localparam int SW = $clog2(SILENT_CLKS + 1);

    logic [SW-1:0] silent_q;
    logic [CW-1:0] waits_q;

    assign timeout_o = silent_i && (silent_q == SW'(SILENT_CLKS - 1));
    assign waits_o   = waits_q;

    generate
        if (MAX_WAIT == 0) begin : g_unbounded
            assign limit_o = 1'b0;
        end else begin : g_bounded
            assign limit_o = wait_i && (waits_q == CW'(MAX_WAIT));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            silent_q <= '0;
            waits_q  <= '0;
        end else if (wait_i) begin
            silent_q <= '0;
            if (!limit_o && (waits_q != '1)) begin
                waits_q <= waits_q + 1'b1;
            end
        end else if (silent_i && !timeout_o) begin
            silent_q <= silent_q + 1'b1;
        end
    end

endmodule

// File: rtl/lpc_abort_seq.sv
module lpc_abort_seq #(
    parameter int ABORT_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    output logic       last_o,
    output logic       lframe_n_o,
    output logic       lad_oe_o,
    output logic [3:0] lad_o
);

    localparam int AW = (ABORT_CLKS > 1) ? $clog2(ABORT_CLKS) : 1;

    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o     = active_i && (cnt_q == AW'(ABORT_CLKS - 1));
    assign lframe_n_o = !active_i;
    assign lad_oe_o   = active_i;
    assign lad_o      = active_i ? 4'b1111 : 4'b0000;

endmodule

// File: rtl/lpc_sync_monitor.sv
module lpc_sync_monitor
    import lpc_sync_pkg::*;
#(
    parameter int SILENT_CLKS = 4,
    parameter int ABORT_CLKS  = 4,
    parameter int MAX_WAIT    = 0,
    parameter int WAIT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        cyc_type_i,
    input  logic [3:0]        lad_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe_o,
    output logic              lframe_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic              serr_o,
    output logic              fwh_err_o,
    output logic [WAIT_W-1:0] wait_cnt_o
);

    st_e  state_q, state_d;
    cyc_e typ_q;
    cls_e cls;

    logic timeout, limit, abort_last;
    logic in_sync, launch;
    logic fin, bail, serr_d, fwh_d;
    res_e fin_res;

    logic done_q, serr_q, fwh_q;
    res_e res_q;

    assign in_sync = (state_q == ST_SYNC);
    assign launch  = (state_q == ST_IDLE) && start_i;

    lpc_sync_decode u_decode (
        .code_i (lad_i),
        .cyc_i  (typ_q),
        .cls_o  (cls)
    );

    lpc_sync_wait_track #(
        .SILENT_CLKS (SILENT_CLKS),
        .MAX_WAIT    (MAX_WAIT),
        .CW          (WAIT_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (launch),
        .wait_i    (in_sync && (cls == CL_WAIT)),
        .silent_i  (in_sync && (cls == CL_SILENT)),
        .timeout_o (timeout),
        .limit_o   (limit),
        .waits_o   (wait_cnt_o)
    );

    lpc_abort_seq #(
        .ABORT_CLKS (ABORT_CLKS)
    ) u_abort (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (state_q == ST_ABORT),
        .last_o     (abort_last),
        .lframe_n_o (lframe_n_o),
        .lad_oe_o   (lad_oe_o),
        .lad_o      (lad_o)
    );

    // State register and latched cycle type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            typ_q   <= CYC_MEM;
        end else begin
            state_q <= state_d;
            if (launch) begin
                typ_q <= cyc_e'(cyc_type_i);
            end
        end
    end

    // Next state and end-of-cycle decision.
    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        bail    = 1'b0;
        fin_res = RES_READY;
        serr_d  = 1'b0;
        fwh_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_SYNC;            // launch
                end
            end
            ST_SYNC: begin
                unique case (cls)
                    CL_READY:   begin fin = 1'b1; fin_res = RES_READY; end
                    CL_MORE:    begin fin = 1'b1; fin_res = RES_MORE;  end
                    CL_ERR:     begin fin = 1'b1; fin_res = RES_ERROR; serr_d = 1'b1; end
                    CL_FWH_ERR: begin bail = 1'b1; fwh_d = 1'b1; end
                    CL_WAIT:    bail = limit;
                    CL_SILENT:  bail = timeout;
                    CL_BAD:     bail = 1'b1;
                    default:    bail = 1'b1;
                endcase
                if (fin) begin
                    state_d = ST_IDLE;            // complete
                end else if (bail) begin
                    state_d = ST_ABORT;           // bail
                end
            end
            ST_ABORT: begin
                if (abort_last) begin
                    state_d = ST_IDLE;            // release
                    fin     = 1'b1;
                    fin_res = RES_ABORT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= RES_READY;
            serr_q <= 1'b0;
            fwh_q  <= 1'b0;
        end else begin
            done_q <= fin;
            serr_q <= serr_d;
            fwh_q  <= fwh_d;
            if (fin) begin
                res_q <= fin_res;
            end
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign result_o  = res_q;
    assign serr_o    = serr_q;
    assign fwh_err_o = fwh_q;

endmodule

// File: rtl/lpc_sync_monitor_chk.sv
module lpc_sync_monitor_chk #(
    parameter int ABORT_CLKS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       done_o,
    input logic [1:0] result_o,
    input logic       serr_o,
    input logic       fwh_err_o,
    input logic       lframe_n_o,
    input logic       lad_oe_o,
    input logic [3:0] lad_o,
    input logic       busy_o,
    input logic [1:0] typ_q
);

    logic [7:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || lframe_n_o) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_more_only_dma_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == 2'd1) |-> (typ_q == 2'd2));

    assert_serr_with_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> (done_o && result_o == 2'd2));

    assert_fwh_err_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fwh_err_o |-> (!lframe_n_o && !serr_o));

    assert_abort_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n_o |-> (lad_oe_o && lad_o == 4'b1111 && busy_o));

    assert_abort_not_long_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n_o |-> (low_cnt < 8'(ABORT_CLKS)));

    assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lframe_n_o) |-> (low_cnt == 8'(ABORT_CLKS) && done_o && result_o == 2'd3));

endmodule

bind lpc_sync_monitor lpc_sync_monitor_chk #(.ABORT_CLKS(ABORT_CLKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_o     (done_o),
    .result_o   (result_o),
    .serr_o     (serr_o),
    .fwh_err_o  (fwh_err_o),
    .lframe_n_o (lframe_n_o),
    .lad_oe_o   (lad_oe_o),
    .lad_o      (lad_o),
    .busy_o     (busy_o),
    .typ_q      (typ_q)
);

// File: tb/lpc_sync_monitor_tb.sv
`timescale 1ns/1ps
module lpc_sync_monitor_tb;

    localparam int MAXW = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] typ = 2'd0;
    logic [3:0] lad = 4'hF;

    logic [3:0] lad_o;
    logic       lad_oe, lframe_n, busy, done, serr, fwh_err;
    logic [1:0] result;
    logic [7:0] wait_cnt;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    lpc_sync_monitor #(.MAX_WAIT(MAXW), .WAIT_W(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cyc_type_i (typ),
        .lad_i      (lad),
        .lad_o      (lad_o),
        .lad_oe_o   (lad_oe),
        .lframe_n_o (lframe_n),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result),
        .serr_o     (serr),
        .fwh_err_o  (fwh_err),
        .wait_cnt_o (wait_cnt)
    );

    // Behavioural reference model: phase 0 idle, 1 sync, 2 abort.
    int m_ph, m_typ, m_sil, m_waits, m_ab;
    int e_done, e_res, e_serr, e_fwh;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_typ = 0; m_sil = 0; m_waits = 0; m_ab = 0;
            e_done = 0; e_res = 0; e_serr = 0; e_fwh = 0;
        end else begin
            e_done = 0; e_serr = 0; e_fwh = 0;
            if (m_ph == 0) begin
                if (start) begin
                    m_ph = 1; m_typ = int'(typ); m_sil = 0; m_waits = 0;
                end
            end else if (m_ph == 1) begin
                if (lad == 4'h0) begin
                    e_done = 1; e_res = 0; m_ph = 0;
                end else if (lad == 4'h9) begin
                    if (m_typ == 2) begin e_done = 1; e_res = 1; m_ph = 0; end
                    else begin m_ph = 2; m_ab = 0; end
                end else if (lad == 4'hA) begin
                    if (m_typ == 3) begin e_fwh = 1; m_ph = 2; m_ab = 0; end
                    else begin e_done = 1; e_res = 2; e_serr = 1; m_ph = 0; end
                end else if (lad == 4'h5 || lad == 4'h6) begin
                    if (MAXW != 0 && m_waits == MAXW) begin m_ph = 2; m_ab = 0; end
                    else begin m_waits++; m_sil = 0; end
                end else if (lad == 4'hF) begin
                    if (m_sil == 3) begin m_ph = 2; m_ab = 0; end
                    else m_sil++;
                end else begin
                    m_ph = 2; m_ab = 0;
                end
            end else begin
                if (m_ab == 3) begin e_done = 1; e_res = 3; m_ph = 0; end
                else m_ab++;
            end
        end
    end

    task automatic chk(input string sig, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, sig, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("done_o",     int'(done),     e_done);
            chk("result_o",   int'(result),   e_res);
            chk("serr_o",     int'(serr),     e_serr);
            chk("fwh_err_o",  int'(fwh_err),  e_fwh);
            chk("busy_o",     int'(busy),     (m_ph != 0) ? 1 : 0);
            chk("lframe_n_o", int'(lframe_n), (m_ph == 2) ? 0 : 1);
            chk("lad_oe_o",   int'(lad_oe),   (m_ph == 2) ? 1 : 0);
            chk("lad_o",      int'(lad_o),    (m_ph == 2) ? 15 : 0);
            chk("wait_cnt_o", int'(wait_cnt), m_waits);
        end
    end

    task automatic step(input logic s, input logic [1:0] t, input logic [3:0] c);
        @(negedge clk);
        start = s; typ = t; lad = c;
    endtask

    logic [3:0] seq[$];

    task automatic run(input string req, input logic [1:0] t, input logic hold);
        cur_req = req;
        step(1'b1, t, 4'hF);
        foreach (seq[i]) step(hold, t, seq[i]);
        for (int k = 0; k < 7; k++) step(1'b0, t, 4'hF);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs under reset
        cur_req = "R1";
        chk("lframe_n_o", int'(lframe_n), 1);
        chk("lad_oe_o",   int'(lad_oe),   0);
        chk("lad_o",      int'(lad_o),    0);
        chk("done_o",     int'(done),     0);
        chk("serr_o",     int'(serr),     0);
        chk("fwh_err_o",  int'(fwh_err),  0);
        chk("busy_o",     int'(busy),     0);
        chk("wait_cnt_o", int'(wait_cnt), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        seq = {4'h0};                         run("R3", 2'd0, 1'b0);
        seq = {4'h5, 4'h6, 4'h5, 4'h0};       run("R4", 2'd1, 1'b0);
        seq = {4'h6, 4'h9};                   run("R5", 2'd2, 1'b0);
        seq = {4'h9};                         run("R5", 2'd1, 1'b0);
        seq = {4'h9};                         run("R5", 2'd3, 1'b0);
        seq = {4'h5, 4'hA};                   run("R6", 2'd0, 1'b0);
        seq = {4'hA};                         run("R6", 2'd2, 1'b0);
        seq = {4'h6, 4'hA};                   run("R7", 2'd3, 1'b0);
        seq = {4'hF, 4'hF, 4'hF, 4'hF};       run("R8", 2'd0, 1'b0);
        seq = {4'hF, 4'hF, 4'hF, 4'h5, 4'hF, 4'hF, 4'hF, 4'h0};
                                              run("R8", 2'd1, 1'b0);
        seq = {4'h3};                         run("R9", 2'd0, 1'b0);
        seq = {4'h5, 4'hC};                   run("R9", 2'd2, 1'b0);
        seq = {4'h6, 4'h6, 4'h6, 4'h6, 4'h6, 4'h6, 4'h0};
                                              run("R11", 2'd3, 1'b0);
        seq = {4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'h5};
                                              run("R11", 2'd1, 1'b0);
        seq = {4'h5, 4'h5, 4'h0};             run("R2", 2'd1, 1'b1);
        seq = {4'h7};                         run("R10", 2'd2, 1'b0);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule